// File: doc/BRIEF.md
# PHY Discovery and Link Resolver

This block is a hardware sequencer that sits in front of an MDIO management controller and brings a link up without software. After a start pulse it walks the PHY address space looking for the first device that answers its identifier register with a plausible value. It reads that device's control register once, then polls its status register until the link is up and auto-negotiation has either finished or is switched off. Finally it works out the speed and duplex the MAC should use.

The result is a set of registered outputs: the PHY address, a found flag, a link-up flag, a 100 Mbps bit and a full-duplex bit. A one-cycle done pulse marks the cycle in which they change. The polling window is a cycle-count parameter, so the same block serves any clock rate. Its default is four seconds at 125 MHz. The block drives read requests only and leaves configuration of the MAC to the logic that consumes its outputs.

Top module: `phy_link_resolver`

## Requirements
- R1: After start, the block reads register 2 at PHY addresses 0, 1, 2, … in increasing order and selects the first address whose value is neither 0xFFFF nor 0x0000. That address appears on `phy_addr` with `phy_found` = 1.
- R2: If no address up to the last one (31 by default) qualifies, the result is `phy_found` = 0, `link_up` = 0, `speed100` = 1, `full_duplex` = 1 and `phy_addr` = 0.
- R3: Once a PHY is selected, the block reads register 0 exactly once. It then reads register 1 repeatedly until bit 2 (link) is set and either bit 12 of register 0 (auto-negotiation enable) is clear or bit 5 of register 1 (negotiation complete) is set.
- R4: Polling stops once a status read finds the poll window of `TIMEOUT_CYCLES` cycles used up. If link is then still down, the result is `link_up` = 0 with `speed100` = 1 and `full_duplex` = 1.
- R5: With negotiation enabled and complete, the block reads registers 4 and 5 and ANDs them. It then takes the first set bit in the order bit 8 (100 full), bit 7 (100 half), bit 6 (10 full), bit 5 (10 half).
- R6: If that AND has none of bits 8..5 set, the result is 100 Mbps full duplex.
- R7: With the link up but negotiation disabled or not completed in the window, `speed100` equals bit 13 and `full_duplex` equals bit 8 of register 0.
- R8: `done` is a single-cycle pulse in the cycle the outputs take a new result. The outputs and `mdio_req` stay unchanged from then until the next start, even if the PHY's registers change.
- R9: A start during a running sequence restarts it from address 0. A response to a request issued before the restart is discarded, and only the restarted sequence produces a result.
- R10: `mdio_req` stays high with `mdio_phy` and `mdio_reg` stable until the cycle in which `rsp_valid` is seen, drops on the next cycle, and only one request is ever outstanding.
- R11: During and right after reset all result outputs, `done` and `mdio_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin (or restart) discovery |
| mdio_req | output | 1 | Read request to the MDIO controller |
| mdio_phy | output | PHY_AW | PHY address of the request |
| mdio_reg | output | REG_AW | Register number of the request |
| rsp_valid | input | 1 | Read data valid, one cycle per request |
| rsp_data | input | DW | Read data |
| phy_addr | output | PHY_AW | Selected PHY address |
| phy_found | output | 1 | A PHY answered the scan |
| link_up | output | 1 | Link reported up |
| speed100 | output | 1 | 1 = 100 Mbps, 0 = 10 Mbps |
| full_duplex | output | 1 | 1 = full duplex |
| done | output | 1 | Result pulse |

## Verification
The assertions take for granted that the MDIO controller raises `rsp_valid` only while `mdio_req` is high, for one cycle per request. The request-hold and register-legality properties rely on this. The bench's responder model waits a fixed latency after seeing a request, answers once, and stays silent until the request falls and a new one appears, so it never answers an idle bus. The bench drives `start` only at the falling edge, so the restart case also covers a restart that lands while a response is still pending.

// File: rtl/phy_link_resolver_pkg.sv
package phy_link_resolver_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SCAN,
      ST_CTRL,
      ST_STAT,
      ST_ADV,
      ST_LPA
   } seq_state_t;

   typedef struct packed {
      logic spd100;
      logic fdx;
   } link_mode_t;

   // management register numbers
   localparam int RN_CTRL = 0;
   localparam int RN_STAT = 1;
   localparam int RN_ID   = 2;
   localparam int RN_ADV  = 4;
   localparam int RN_LPA  = 5;

   // bit positions
   localparam int B_LINK    = 2;
   localparam int B_ANDONE  = 5;
   localparam int B_AN_EN   = 12;
   localparam int B_SPD100  = 13;
   localparam int B_FDX     = 8;

   // abilities, highest priority first
   localparam int NUM_ABIL = 4;
   localparam int ABIL_BIT [NUM_ABIL] = '{8, 7, 6, 5};

   localparam link_mode_t MODE_DEFAULT = '{spd100: 1'b1, fdx: 1'b1};

endpackage

// File: rtl/plr_mdio_port.sv
module plr_mdio_port #(
   parameter int PHY_AW = 5,
   parameter int REG_AW = 5,
   parameter int DW     = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic              abort,
   input  logic [PHY_AW-1:0] in_phy,
   input  logic [REG_AW-1:0] in_reg,
   input  logic              rsp_valid,
   input  logic [DW-1:0]     rsp_data,
   output logic              req,
   output logic [PHY_AW-1:0] req_phy,
   output logic [REG_AW-1:0] req_reg,
   output logic              ready,
   output logic              rd_done,
   output logic [DW-1:0]     rd_data
);

   logic busy;
   logic drop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         drop    <= 1'b0;
         req_phy <= '0;
         req_reg <= '0;
         rd_done <= 1'b0;
         rd_data <= '0;
      end else begin
         rd_done <= 1'b0;
         if (busy) begin
            if (rsp_valid) begin
               busy <= 1'b0;
               drop <= 1'b0;
               if (!drop && !abort) begin
                  rd_done <= 1'b1;
                  rd_data <= rsp_data;
               end
            end else if (abort) begin
               drop <= 1'b1;
            end
         end else if (issue) begin
            busy    <= 1'b1;
            req_phy <= in_phy;
            req_reg <= in_reg;
         end
      end
   end

   assign req   = busy;
   assign ready = !busy;

endmodule

// File: rtl/plr_poll_timer.sv
module plr_poll_timer #(
   parameter longint unsigned LIMIT = 500_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic expired
);

   localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIM = CW'(LIMIT);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clear)
         cnt <= '0;
      else if (run && !expired)
         cnt <= cnt + 1'b1;
   end

   assign expired = (cnt >= LIM);

endmodule

// File: rtl/plr_mode_pick.sv
module plr_mode_pick
   import phy_link_resolver_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic [DW-1:0] common,
   output link_mode_t    mode
);

   logic [NUM_ABIL-1:0] ab;
   logic [NUM_ABIL-1:0] win;
   logic [NUM_ABIL:0]   taken;

   assign taken[0] = 1'b0;

   for (genvar i = 0; i < NUM_ABIL; i++) begin : g_prio
      assign ab[i]      = common[ABIL_BIT[i]];
      assign win[i]     = ab[i] & ~taken[i];
      assign taken[i+1] = taken[i] | ab[i];
   end

   // win[0]=100F, win[1]=100H, win[2]=10F, win[3]=10H
   always_comb begin
      if (!taken[NUM_ABIL]) begin
         mode = MODE_DEFAULT;
      end else begin
         mode.spd100 = win[0] | win[1];
         mode.fdx    = win[0] | win[2];
      end
   end

endmodule

// File: rtl/phy_link_resolver.sv
module phy_link_resolver
   import phy_link_resolver_pkg::*;
#(
   parameter int              PHY_AW         = 5,
   parameter int              REG_AW         = 5,
   parameter int              DW             = 16,
   parameter int              SCAN_LAST      = 31,
   parameter longint unsigned TIMEOUT_CYCLES = 500_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              mdio_req,
   output logic [PHY_AW-1:0] mdio_phy,
   output logic [REG_AW-1:0] mdio_reg,
   input  logic              rsp_valid,
   input  logic [DW-1:0]     rsp_data,
   output logic [PHY_AW-1:0] phy_addr,
   output logic              phy_found,
   output logic              link_up,
   output logic              speed100,
   output logic              full_duplex,
   output logic              done
);

   localparam logic [PHY_AW-1:0] ADDR_LAST = PHY_AW'(SCAN_LAST);
   localparam logic [DW-1:0]     ID_ONES   = '1;

   if (PHY_AW < 1 || SCAN_LAST < 0 || SCAN_LAST >= (1 << PHY_AW)) begin : g_bad_scan
      $error("phy_link_resolver: SCAN_LAST does not fit PHY_AW");
   end
   if (REG_AW < 3) begin : g_bad_reg
      $error("phy_link_resolver: REG_AW too small for register 5");
   end
   if (DW < 14) begin : g_bad_dw
      $error("phy_link_resolver: DW must hold bit 13");
   end

   seq_state_t        state, nxt_state;
   logic              pend;
   logic [PHY_AW-1:0] cur_addr;
   logic [DW-1:0]     ctrl_q;
   logic [DW-1:0]     adv_q;

   logic              port_ready, rd_done, issue;
   logic [DW-1:0]     rd_data;
   logic [REG_AW-1:0] want_reg;
   logic              tmr_clear, tmr_expired;
   link_mode_t        nego_mode;

   logic              fin, fin_found, fin_link, addr_inc;
   link_mode_t        fin_mode;

   // read request port
   always_comb begin
      unique case (state)
         ST_SCAN: want_reg = REG_AW'(RN_ID);
         ST_CTRL: want_reg = REG_AW'(RN_CTRL);
         ST_STAT: want_reg = REG_AW'(RN_STAT);
         ST_ADV:  want_reg = REG_AW'(RN_ADV);
         ST_LPA:  want_reg = REG_AW'(RN_LPA);
         default: want_reg = REG_AW'(RN_ID);
      endcase
   end

   assign issue = (state != ST_IDLE) && !pend && port_ready && !start;

   plr_mdio_port #(.PHY_AW(PHY_AW), .REG_AW(REG_AW), .DW(DW)) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .issue     (issue),
      .abort     (start),
      .in_phy    (cur_addr),
      .in_reg    (want_reg),
      .rsp_valid (rsp_valid),
      .rsp_data  (rsp_data),
      .req       (mdio_req),
      .req_phy   (mdio_phy),
      .req_reg   (mdio_reg),
      .ready     (port_ready),
      .rd_done   (rd_done),
      .rd_data   (rd_data)
   );

   // status poll window
   assign tmr_clear = start || (state == ST_CTRL && rd_done);

   plr_poll_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (tmr_clear),
      .run     (state == ST_STAT),
      .expired (tmr_expired)
   );

   // negotiated mode
   plr_mode_pick #(.DW(DW)) u_pick (
      .common (adv_q & rd_data),
      .mode   (nego_mode)
   );

   // sequencing decisions
   always_comb begin
      nxt_state = state;
      fin       = 1'b0;
      fin_found = 1'b1;
      fin_link  = 1'b1;
      fin_mode  = MODE_DEFAULT;
      addr_inc  = 1'b0;
      if (rd_done) begin
         unique case (state)
            ST_SCAN: begin
               if (rd_data != ID_ONES && rd_data != '0) begin
                  nxt_state = ST_CTRL;
               end else if (cur_addr == ADDR_LAST) begin
                  fin       = 1'b1;
                  fin_found = 1'b0;
                  fin_link  = 1'b0;
               end else begin
                  addr_inc  = 1'b1;
               end
            end
            ST_CTRL: nxt_state = ST_STAT;
            ST_STAT: begin
               if ((rd_data[B_LINK] && (!ctrl_q[B_AN_EN] || rd_data[B_ANDONE]))
                   || tmr_expired) begin
                  if (!rd_data[B_LINK]) begin
                     fin      = 1'b1;
                     fin_link = 1'b0;
                  end else if (ctrl_q[B_AN_EN] && rd_data[B_ANDONE]) begin
                     nxt_state = ST_ADV;
                  end else begin
                     fin             = 1'b1;
                     fin_mode.spd100 = ctrl_q[B_SPD100];
                     fin_mode.fdx    = ctrl_q[B_FDX];
                  end
               end
            end
            ST_ADV: nxt_state = ST_LPA;
            ST_LPA: begin
               fin      = 1'b1;
               fin_mode = nego_mode;
            end
            default: nxt_state = ST_IDLE;
         endcase
         if (fin)
            nxt_state = ST_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         pend        <= 1'b0;
         cur_addr    <= '0;
         ctrl_q      <= '0;
         adv_q       <= '0;
         phy_addr    <= '0;
         phy_found   <= 1'b0;
         link_up     <= 1'b0;
         speed100    <= 1'b0;
         full_duplex <= 1'b0;
         done        <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            state    <= ST_SCAN;
            pend     <= 1'b0;
            cur_addr <= '0;
         end else begin
            if (issue)
               pend <= 1'b1;
            if (rd_done) begin
               pend  <= 1'b0;
               state <= nxt_state;
               if (state == ST_CTRL)
                  ctrl_q <= rd_data;
               if (state == ST_ADV)
                  adv_q <= rd_data;
               if (addr_inc)
                  cur_addr <= cur_addr + 1'b1;
               if (fin) begin
                  done        <= 1'b1;
                  phy_found   <= fin_found;
                  phy_addr    <= fin_found ? cur_addr : '0;
                  link_up     <= fin_link;
                  speed100    <= fin_mode.spd100;
                  full_duplex <= fin_mode.fdx;
               end
            end
         end
      end
   end

endmodule

// File: rtl/phy_link_resolver_chk.sv
module phy_link_resolver_chk #(
   parameter int PHY_AW = 5,
   parameter int REG_AW = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rsp_valid,
   input logic              mdio_req,
   input logic [PHY_AW-1:0] mdio_phy,
   input logic [REG_AW-1:0] mdio_reg,
   input logic [PHY_AW-1:0] phy_addr,
   input logic              phy_found,
   input logic              link_up,
   input logic              speed100,
   input logic              full_duplex,
   input logic              done
);

   a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mdio_req && !rsp_valid) |=> (mdio_req && $stable(mdio_phy) && $stable(mdio_reg)));

   a_r10_req_release: assert property (@(posedge clk) disable iff (!rst_n)
      (mdio_req && rsp_valid) |=> !mdio_req);

   a_r1_reg_legal: assert property (@(posedge clk) disable iff (!rst_n)
      mdio_req |-> (mdio_reg == 0 || mdio_reg == 1 || mdio_reg == 2 ||
                    mdio_reg == 4 || mdio_reg == 5));

   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable({phy_addr, phy_found, link_up, speed100, full_duplex}));

   a_r2_none_default: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !phy_found) |-> (!link_up && speed100 && full_duplex && phy_addr == '0));

   a_r4_down_default: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !link_up) |-> (speed100 && full_duplex));

endmodule

bind phy_link_resolver phy_link_resolver_chk #(.PHY_AW(PHY_AW), .REG_AW(REG_AW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rsp_valid   (rsp_valid),
   .mdio_req    (mdio_req),
   .mdio_phy    (mdio_phy),
   .mdio_reg    (mdio_reg),
   .phy_addr    (phy_addr),
   .phy_found   (phy_found),
   .link_up     (link_up),
   .speed100    (speed100),
   .full_duplex (full_duplex),
   .done        (done)
);

// File: tb/phy_link_resolver_bench.sv
`timescale 1ns/1ps
module phy_link_resolver_bench;

   localparam int NEVER = 100000;
   localparam int LAT   = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        rsp_valid = 1'b0;
   logic [15:0] rsp_data = '0;
   logic        mdio_req;
   logic [4:0]  mdio_phy, mdio_reg, phy_addr;
   logic        phy_found, link_up, speed100, full_duplex, done;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   phy_link_resolver #(.TIMEOUT_CYCLES(400)) u_phy_link_resolver (
      .clk(clk), .rst_n(rst_n), .start(start),
      .mdio_req(mdio_req), .mdio_phy(mdio_phy), .mdio_reg(mdio_reg),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .phy_addr(phy_addr), .phy_found(phy_found), .link_up(link_up),
      .speed100(speed100), .full_duplex(full_duplex), .done(done)
   );

   // PHY model
   logic [15:0] id_tab [32];
   logic [15:0] m_ctrl, m_adv, m_lpa;
   int link_after, anc_after, stat_polls, ctrl_reads;

   typedef struct packed {
      logic       found;
      logic       link;
      logic       spd;
      logic       fdx;
      logic [4:0] addr;
   } res_t;

   res_t exp_q[$];
   res_t last_exp;

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] model_rd(input logic [4:0] pa, input logic [4:0] rn);
      logic [15:0] v;
      v = '0;
      case (rn)
         5'd2: v = id_tab[pa];
         5'd0: v = m_ctrl;
         5'd1: begin
            v[2] = (stat_polls >= link_after);
            v[5] = (stat_polls >= anc_after);
         end
         5'd4: v = m_adv;
         5'd5: v = m_lpa;
         default: v = 16'hDEAD;
      endcase
      return v;
   endfunction

   // responder
   initial begin
      int cnt;
      cnt = 0;
      forever begin
         @(negedge clk);
         if (rsp_valid) begin
            rsp_valid = 1'b0;
            cnt = 0;
         end else if (mdio_req) begin
            cnt++;
            if (cnt >= LAT) begin
               if (mdio_reg == 5'd1) stat_polls++;
               if (mdio_reg == 5'd0) ctrl_reads++;
               rsp_data  = model_rd(mdio_phy, mdio_reg);
               rsp_valid = 1'b1;
               cnt = 0;
            end
         end
      end
   end

   // expected result from the requirements
   function automatic res_t predict();
      res_t r;
      logic [15:0] c;
      int fa;
      fa = -1;
      for (int a = 31; a >= 0; a--)
         if (id_tab[a] != 16'hFFFF && id_tab[a] != 16'h0000) fa = a;
      r = '{found: 1'b0, link: 1'b0, spd: 1'b1, fdx: 1'b1, addr: 5'd0};
      if (fa < 0) return r;                                  // R2
      r.found = 1'b1;
      r.addr  = 5'(fa);                                      // R1
      if (link_after >= NEVER) return r;                     // R4
      r.link = 1'b1;
      if (m_ctrl[12] && anc_after < NEVER) begin             // R5
         c = m_adv & m_lpa;
         if (c[8])      begin r.spd = 1; r.fdx = 1; end
         else if (c[7]) begin r.spd = 1; r.fdx = 0; end
         else if (c[6]) begin r.spd = 0; r.fdx = 1; end
         else if (c[5]) begin r.spd = 0; r.fdx = 0; end      // else R6 default
      end else begin                                         // R7
         r.spd = m_ctrl[13];
         r.fdx = m_ctrl[8];
      end
      return r;
   endfunction

   // monitor
   initial begin
      res_t e;
      forever begin
         @(negedge clk);
         if (done) begin
            if (exp_q.size() == 0) begin
               checks++; errors++;
               $display("FAIL R8/R9: unexpected done, actual 1 expected 0");
            end else begin
               e = exp_q.pop_front();
               chk("R1 phy_found", 8'(phy_found), 8'(e.found));
               chk("R1 phy_addr",  8'(phy_addr),  8'(e.addr));
               chk("R4 link_up",   8'(link_up),   8'(e.link));
               chk("R5 speed100",  8'(speed100),  8'(e.spd));
               chk("R7 full_duplex", 8'(full_duplex), 8'(e.fdx));
            end
         end
      end
   end

   task automatic reset_model();
      for (int a = 0; a < 32; a++) id_tab[a] = 16'hFFFF;
      m_ctrl = '0; m_adv = '0; m_lpa = '0;
      link_after = 0; anc_after = 0; stat_polls = 0; ctrl_reads = 0;
   endtask

   task automatic pulse_start();
      @(negedge clk);
      stat_polls = 0; ctrl_reads = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic run_case(input string name);
      last_exp = predict();
      exp_q.push_back(last_exp);
      pulse_start();
      for (int i = 0; i < 5000 && exp_q.size() != 0; i++) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R8 %s: no done, actual 0 expected 1", name);
         exp_q.delete();
      end
      repeat (3) @(negedge clk);
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      reset_model();
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 outputs in reset", {3'b0, phy_found, link_up, speed100, full_duplex, done}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 after reset", {phy_found, link_up, speed100, full_duplex, done, mdio_req, 2'b0}, 8'h00);

      // R2: no PHY anywhere
      id_tab[7] = 16'h0000;
      run_case("R2 none");

      // R1 + R5: PHY at 5, 0000 at 3, common = 100H|10F -> 100 half
      reset_model();
      id_tab[3] = 16'h0000; id_tab[5] = 16'h0141; id_tab[9] = 16'h0022;
      m_ctrl = 16'h1000; m_adv = 16'h01E0; m_lpa = 16'h00C0;
      run_case("R5 100H");
      chk("R3 ctrl read once", 8'(ctrl_reads), 8'd1);

      // R5: only 10F common
      m_adv = 16'h0060; m_lpa = 16'h0140;
      run_case("R5 10F");
      // R5: only 10H
      m_adv = 16'h0020; m_lpa = 16'h01E0;
      run_case("R5 10H");
      // R5: everything -> 100F
      m_adv = 16'h01E0; m_lpa = 16'h01E0;
      run_case("R5 100F");
      // R6: empty intersection
      m_adv = 16'h0180; m_lpa = 16'h0060;
      run_case("R6 empty");

      // R3 + R7: AN off, link after 3 polls, 10 full forced
      m_ctrl = 16'h0100; link_after = 3; anc_after = NEVER;
      run_case("R7 forced 10F");
      checks++;
      if (stat_polls != 3) begin
         errors++;
         $display("FAIL R3 polls: actual %0d expected 3", stat_polls);
      end

      // R4: link never comes up
      m_ctrl = 16'h1000; link_after = NEVER;
      run_case("R4 timeout down");

      // R7 after timeout: AN on but never completes, link up
      m_ctrl = 16'h3000; link_after = 2; anc_after = NEVER;
      run_case("R7 timeout forced 100H");

      // R1: PHY only at the last address
      reset_model();
      id_tab[31] = 16'h7777; m_ctrl = 16'h2100;
      run_case("R1 last addr");

      // R8: outputs hold while PHY changes
      m_ctrl = 16'h0000; id_tab[0] = 16'h1234;
      repeat (60) @(negedge clk);
      chk("R8 hold", {phy_found, link_up, speed100, full_duplex, phy_addr[3:0]},
          {last_exp.found, last_exp.link, last_exp.spd, last_exp.fdx, last_exp.addr[3:0]});
      chk("R8 no request idle", 8'(mdio_req), 8'd0);

      // R9: restart mid-sequence, only the second result counts
      reset_model();
      id_tab[20] = 16'h0A0A; m_ctrl = 16'h1000; m_adv = 16'h0100; m_lpa = 16'h0100;
      pulse_start();
      repeat (17) @(negedge clk);
      id_tab[20] = 16'hFFFF; id_tab[2] = 16'h0B0B;
      m_ctrl = 16'h0000; link_after = 0;
      run_case("R9 restart");
      chk("R9 addr after restart", 8'(phy_addr), 8'd2);

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule